// File: doc/BRIEF.md
# Protected Register Write Guard

This block sits on a simple synchronous register bus and shields two byte-wide control registers, one for clock control and one for power-save control, from stray writes by software that has lost its way. Software must first write any value to a command location, which arms the guard. Only the bus cycle that comes straight after the arming write may change a protected register. If any other bus cycle comes in between, the guard disarms. A protected write made while the guard is disarmed is dropped, and a sticky protection-error flag is set in a status location.

Bus cycles are single-cycle writes and reads, qualified by `busWr` and `busRd`. A write can be a plain store, or it can set, clear or toggle bits against the current contents. These bit operations obey the same unlock rule as a plain store. Read data is registered. The protected register contents are also driven out on dedicated ports, where the clock and power logic can use them.

Top module: `prot_reg_guard`

## Requirements
- R1: After reset the guard is disarmed and the error flag is 0. The clock-control register holds 8'h03 and the power-save register holds 8'h00. `busRdata` is 8'h00.
- R2: A write of any data value to the command address (4'h0) arms the guard and changes no register. A read of the command address returns 8'h00.
- R3: A write to the clock-control address (4'h1) or to the power-save address (4'h2) that comes directly after an arming write updates that register. The new value appears on `clkCtlOut` or `pwrCtlOut` after the capturing clock edge. Idle cycles, with neither `busWr` nor `busRd` set, do not count as bus cycles.
- R4: Any bus cycle other than a command write disarms the guard. This covers reads and writes to any address, including the status address and unmapped addresses. A further command write keeps the guard armed.
- R5: A write to a protected address while the guard is disarmed leaves that register unchanged and sets the error flag to 1.
- R6: `busBitOp` selects how a write combines with the current contents. 0 stores the data, 1 sets bits (cur | data), 2 clears bits (cur & ~data) and 3 toggles bits (cur ^ data). Bit operations on protected registers follow the unlock rule of R3 and R5.
- R7: Bit 0 of the status location (4'h3) is the error flag, and bits 7:1 read as 0. A status write needs no unlock. It clears the flag only when the merged result bit 0 is 0; otherwise the flag holds. Apart from this, only reset clears the flag.
- R8: A read returns the addressed contents on `busRdata` one clock after the read is sampled, with no unlock required. A cycle without a read, or a read of an unmapped address, gives 8'h00. When a read and a write happen in the same cycle, the read returns the value from before the write.
- R9: Writes to unmapped addresses change no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W (4) | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busBitOp | input | 2 | Write combine mode: store, set, clear, toggle |
| busWdata | input | 8 | Write data or bit mask |
| busRdata | output | 8 | Registered read data |
| clkCtlOut | output | 8 | Clock-control register contents |
| pwrCtlOut | output | 8 | Power-save register contents |

## Verification
Each result of a bus cycle is due exactly one clock edge after the cycle is sampled. Register updates and the error flag change at that edge, and `busRdata` is valid from that edge until the next one. The bench drives each cycle at a falling edge and clears the strobes at the next falling edge, checking outputs only then. Its expected values come from a bench model that applies each cycle at the same edge.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;

  typedef enum logic [1:0] {
    OP_STORE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TGL   = 2'd3
  } bitOp_e;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CLK  = 2'd1,
    RD_PWR  = 2'd2,
    RD_STAT = 2'd3
  } rdSel_e;

  // Strobes from control to datapath, valid in the cycle of the bus access.
  typedef struct packed {
    logic   loadClk;
    logic   loadPwr;
    logic   setErr;
    logic   wrStat;
    rdSel_e rdSel;
  } guardStb_t;

  function automatic logic [7:0] mergeByte(input bitOp_e op, input logic [7:0] cur,
                                           input logic [7:0] dat);
    logic [7:0] res;
    unique case (op)
      OP_SET:  res = cur | dat;
      OP_CLR:  res = cur & ~dat;
      OP_TGL:  res = cur ^ dat;
      default: res = dat;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/prot_guard_ctrl.sv
module prot_guard_ctrl
  import prot_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] CLK_ADDR  = 'h1,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output guardStb_t         stb
);

  logic armed;
  logic isCmd, isClk, isPwr, isStat;
  logic anyAccess, cmdWr, protWr;

  assign isCmd     = (busAddr == CMD_ADDR);
  assign isClk     = (busAddr == CLK_ADDR);
  assign isPwr     = (busAddr == PWR_ADDR);
  assign isStat    = (busAddr == STAT_ADDR);
  assign anyAccess = busWr | busRd;
  assign cmdWr     = busWr & isCmd;
  assign protWr    = busWr & (isClk | isPwr);

  // Arm on a command write, drop on any other bus cycle, hold across idle cycles.
  always_ff @(posedge clk) begin
    if (!rstN)          armed <= 1'b0;
    else if (cmdWr)     armed <= 1'b1;
    else if (anyAccess) armed <= 1'b0;
  end

  always_comb begin
    stb.loadClk = busWr & isClk & armed;
    stb.loadPwr = busWr & isPwr & armed;
    stb.setErr  = protWr & ~armed;
    stb.wrStat  = busWr & isStat;
    stb.rdSel   = RD_NONE;
    if (busRd) begin
      if (isClk)       stb.rdSel = RD_CLK;
      else if (isPwr)  stb.rdSel = RD_PWR;
      else if (isStat) stb.rdSel = RD_STAT;
    end
  end

  // R2: a command write leaves the guard armed
  a_r2_cmd_arms: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && isCmd) |=> armed);

  // R4: any other bus cycle leaves the guard disarmed
  a_r4_other_disarms: assert property (@(posedge clk) disable iff (!rstN)
    (anyAccess && !(busWr && isCmd)) |=> !armed);

  // R4: idle cycles keep the armed state
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!anyAccess) |=> $stable(armed));

endmodule

// File: rtl/prot_guard_dp.sv
module prot_guard_dp
  import prot_guard_pkg::*;
#(
  parameter logic [7:0] CLK_RST = 8'h03,
  parameter logic [7:0] PWR_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  guardStb_t  stb,
  input  logic [1:0] busBitOp,
  input  logic [7:0] busWdata,
  output logic [7:0] rdData,
  output logic [7:0] clkCtl,
  output logic [7:0] pwrCtl
);

  logic       errFlag;
  bitOp_e     op;
  logic [7:0] statNow;
  logic [7:0] clkMerged, pwrMerged, statMerged;
  logic [7:0] rdNext;

  assign op         = bitOp_e'(busBitOp);
  assign statNow    = {7'b0, errFlag};
  assign clkMerged  = mergeByte(op, clkCtl, busWdata);
  assign pwrMerged  = mergeByte(op, pwrCtl, busWdata);
  assign statMerged = mergeByte(op, statNow, busWdata);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkCtl <= CLK_RST;
      pwrCtl <= PWR_RST;
    end else begin
      if (stb.loadClk) clkCtl <= clkMerged;
      if (stb.loadPwr) pwrCtl <= pwrMerged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                             errFlag <= 1'b0;
    else if (stb.setErr)                   errFlag <= 1'b1;
    else if (stb.wrStat && !statMerged[0]) errFlag <= 1'b0;
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_CLK:  rdNext = clkCtl;
      RD_PWR:  rdNext = pwrCtl;
      RD_STAT: rdNext = statNow;
      default: rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= 8'h00;
    else       rdData <= rdNext;
  end

  // R3: protected registers change only on an unlocked load strobe
  a_r3_clk_guarded: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadClk |=> $stable(clkCtl));
  a_r3_pwr_guarded: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadPwr |=> $stable(pwrCtl));

  // R5: a dropped protected write raises the error flag
  a_r5_err_raised: assert property (@(posedge clk) disable iff (!rstN)
    stb.setErr |=> errFlag);

  // R7: the flag is sticky unless the status location is written
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !stb.wrStat) |=> errFlag);

  // R8: no read gives zero read data
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdSel == RD_NONE) |=> (rdData == 8'h00));

endmodule

// File: rtl/prot_reg_guard.sv
module prot_reg_guard
  import prot_guard_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h0,
  parameter logic [ADDR_W-1:0] CLK_ADDR  = 'h1,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h2,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3,
  parameter logic [7:0] CLK_RST = 8'h03,
  parameter logic [7:0] PWR_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busBitOp,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic [7:0]        clkCtlOut,
  output logic [7:0]        pwrCtlOut
);

  guardStb_t stb;

  prot_guard_ctrl #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .CLK_ADDR(CLK_ADDR),
    .PWR_ADDR(PWR_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .stb(stb)
  );

  prot_guard_dp #(
    .CLK_RST(CLK_RST), .PWR_RST(PWR_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busBitOp(busBitOp),
    .busWdata(busWdata), .rdData(busRdata),
    .clkCtl(clkCtlOut), .pwrCtl(pwrCtlOut)
  );

endmodule

// File: tb/prot_reg_guard_tb.sv
`timescale 1ns/1ps
module prot_reg_guard_tb;

  localparam logic [3:0] A_CMD = 4'h0, A_CLK = 4'h1, A_PWR = 4'h2, A_STAT = 4'h3;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] busAddr;
  logic       busWr, busRd;
  logic [1:0] busBitOp;
  logic [7:0] busWdata;
  logic [7:0] busRdata, clkCtlOut, pwrCtlOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model
  logic       mArmed, mErr;
  logic [7:0] mClk, mPwr, mRd;

  always #4 clk = ~clk;  // 125 MHz

  prot_reg_guard u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busBitOp(busBitOp), .busWdata(busWdata), .busRdata(busRdata),
    .clkCtlOut(clkCtlOut), .pwrCtlOut(pwrCtlOut)
  );

  function automatic logic [7:0] combine(input logic [1:0] op, input logic [7:0] cur,
                                         input logic [7:0] d);
    if (op == 2'd1) return cur | d;
    if (op == 2'd2) return cur & ~d;
    if (op == 2'd3) return cur ^ d;
    return d;
  endfunction

  function automatic logic [7:0] readModel(input logic [3:0] a);
    if (a == A_CLK)  return mClk;
    if (a == A_PWR)  return mPwr;
    if (a == A_STAT) return {7'b0, mErr};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle, driven at a falling edge, checked at the next falling edge.
  task automatic cyc(input logic wr, input logic rd, input logic [3:0] a,
                     input logic [1:0] op, input logic [7:0] d, input string req);
    logic [7:0] m;
    busWr = wr; busRd = rd; busAddr = a; busBitOp = op; busWdata = d;
    @(posedge clk);
    mRd = rd ? readModel(a) : 8'h00;
    if (wr) begin
      if (a == A_CMD) mArmed = 1'b1;
      else begin
        if (a == A_CLK || a == A_PWR) begin
          if (mArmed) begin
            if (a == A_CLK) mClk = combine(op, mClk, d);
            else            mPwr = combine(op, mPwr, d);
          end else mErr = 1'b1;
        end else if (a == A_STAT) begin
          m = combine(op, {7'b0, mErr}, d);
          if (!m[0]) mErr = 1'b0;
        end
        mArmed = 1'b0;
      end
    end else if (rd) mArmed = 1'b0;
    @(negedge clk);
    busWr = 1'b0; busRd = 1'b0;
    chk({req, " clk reg"}, clkCtlOut, mClk);
    chk({req, " pwr reg"}, pwrCtlOut, mPwr);
    chk({req, " rdata"},   busRdata,  mRd);
  endtask

  task automatic idle();
    busWr = 1'b0; busRd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rdStat(input string req);
    cyc(1'b0, 1'b1, A_STAT, 2'd0, 8'h00, req);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; busWr = 1'b0; busRd = 1'b0; busAddr = '0; busBitOp = '0; busWdata = '0;
    mArmed = 1'b0; mErr = 1'b0; mClk = 8'h03; mPwr = 8'h00; mRd = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 clk reset", clkCtlOut, 8'h03);
    chk("R1 pwr reset", pwrCtlOut, 8'h00);
    chk("R1 rdata reset", busRdata, 8'h00);
    rdStat("R1 status reset");

    // R2 arm with any data, command reads 0; R3 unlocked write
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'hFF, "R2 cmd write FF");
    cyc(1'b1, 1'b0, A_CLK, 2'd0, 8'h5A, "R3 unlocked clk write");
    cyc(1'b0, 1'b1, A_CMD, 2'd0, 8'h00, "R2 cmd read zero");
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h00, "R2 cmd write 00");
    idle(); idle();
    cyc(1'b1, 1'b0, A_PWR, 2'd0, 8'hC3, "R3 write after idle gaps");

    // R5 unarmed write dropped, flag set; R7 status readback
    cyc(1'b1, 1'b0, A_PWR, 2'd0, 8'h11, "R5 unarmed pwr write");
    rdStat("R7 flag set");
    cyc(1'b1, 1'b0, A_STAT, 2'd0, 8'h01, "R7 write 1 holds");
    rdStat("R7 flag still set");
    cyc(1'b1, 1'b0, A_STAT, 2'd0, 8'hFE, "R7 write 0 clears");
    rdStat("R7 flag cleared");

    // R4 an intervening read breaks the sequence
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h3C, "R4 arm");
    cyc(1'b0, 1'b1, A_PWR, 2'd0, 8'h00, "R4 intervening read");
    cyc(1'b1, 1'b0, A_CLK, 2'd0, 8'h77, "R4 broken write dropped");
    rdStat("R4 error after break");
    cyc(1'b1, 1'b0, A_STAT, 2'd2, 8'h01, "R7 clear via bit clear");
    rdStat("R7 cleared by bit op");
    // R4 double command stays armed
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h01, "R4 arm once");
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h02, "R4 arm twice");
    cyc(1'b1, 1'b0, A_CLK, 2'd0, 8'h0F, "R4 write after re-arm");

    // R6 bit operations
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h00, "R6 arm");
    cyc(1'b1, 1'b0, A_CLK, 2'd1, 8'hA0, "R6 set bits");
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h00, "R6 arm");
    cyc(1'b1, 1'b0, A_CLK, 2'd2, 8'h05, "R6 clear bits");
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h00, "R6 arm");
    cyc(1'b1, 1'b0, A_PWR, 2'd3, 8'hFF, "R6 toggle bits");
    cyc(1'b1, 1'b0, A_PWR, 2'd3, 8'hFF, "R6 unarmed toggle dropped");
    rdStat("R6 unarmed bit op error");

    // R9 unmapped write; R8 unmapped read
    cyc(1'b1, 1'b0, A_CMD, 2'd0, 8'h00, "R9 arm");
    cyc(1'b1, 1'b0, 4'h9, 2'd0, 8'hFF, "R9 unmapped write");
    cyc(1'b1, 1'b0, A_CLK, 2'd0, 8'h12, "R9 disarmed by unmapped");
    cyc(1'b0, 1'b1, 4'hE, 2'd0, 8'h00, "R8 unmapped read");
    cyc(1'b1, 1'b1, A_STAT, 2'd0, 8'h00, "R8 read before write");

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 4)       a = A_CMD;
      else if (sel < 6)  a = A_CLK;
      else if (sel < 8)  a = A_PWR;
      else if (sel == 8) a = A_STAT;
      else               a = 4'($urandom_range(4, 15));
      if ($urandom_range(0, 7) == 0) idle();
      cyc(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) == 0), a,
          2'($urandom_range(0, 3)), 8'($urandom), "R8 random traffic");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule